// File: doc/BRIEF.md
# Write-Back Data Cache Controller

This block is a small two-way set-associative data cache that sits between one requesting client and a slower word-addressed backing memory. Each client request is a read, a write or a clean command, and the block looks up the request's tag in the indexed set. A read or write that finds its line is served from local storage. A read that misses brings the word in from memory, installs it and returns it. Before that fetch, the block may have to copy a modified victim line back to memory. A write that misses goes straight to memory and leaves the cache contents untouched.

The victim on a fill is an empty way if the set has one. Otherwise it is the least recently used way, tracked with one bit per set. Written lines are marked dirty and reach memory only when they are evicted or when the client issues a clean command naming that address. Both sides of the block use valid/ready request channels. Memory reads return their data on a separate response strobe. Only one client request is in flight at a time. Two counters report how many reads and writes were accepted and how many of them hit.

Top module: `wbc_cache_top`

## Requirements
- R1: A read (req_op 2'b00) whose tag matches a valid way of set addr[IDX_W-1:0] returns that way's word with rsp_hit=1 and makes no memory transaction.
- R2: A read miss whose victim is clean or empty makes exactly one memory read at the request address, installs the returned word and returns it with rsp_hit=0. A later read of the same address hits.
- R3: A fill takes way 0 if it is invalid, else way 1 if invalid, else the way named by the set's LRU bit. Every hit and every fill sets that bit to the other way.
- R4: A write (req_op 2'b01) that hits updates only the cached word, marks it dirty, answers with rsp_hit=1 and makes no memory transaction.
- R5: A read miss whose victim is valid and dirty first writes the victim word to address {victim tag, index}, then performs the fetch. That is one memory write followed by one memory read.
- R6: A write miss makes exactly one memory write of the request data and installs nothing, so a following read of that address misses.
- R7: A clean command (req_op 2'b10) for a present dirty line makes one memory write of it and clears its dirty bit. For a clean or absent line it makes no memory transaction. rsp_hit reports whether the line was present. Code 2'b11 is handled as a read.
- R8: After reset all lines are invalid and clean, every LRU bit points at way 0, req_ready is 1, rsp_valid and mem_req_valid are 0 and both counters are 0.
- R9: req_ready is high only when idle. It falls in the cycle after a request is accepted and stays low until after the single-cycle rsp_valid pulse.
- R10: access_cnt counts accepted reads and writes, and hit_cnt counts those that hit. Clean commands change neither.
- R11: A memory request held without mem_req_ready keeps its valid, direction, address and data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | 00 read, 01 write, 10 clean, 11 read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | DATA_W | Read data (0 for write and clean) |
| rsp_hit | output | 1 | Line was present at lookup |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | ADDR_W | Memory word address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_rsp_valid | input | 1 | Memory read data strobe |
| mem_rsp_rdata | input | DATA_W | Memory read data |
| access_cnt | output | CNT_W | Accepted reads and writes |
| hit_cnt | output | CNT_W | Hits among them |

## Verification
A directed sequence fills one set from empty, then re-reads it, dirties it and overflows it. This separates the choice of an invalid way from the choice made by LRU, and a clean eviction from a dirty one (R5 ordering, with stamps). Write misses followed by reads show that no line is allocated. Clean commands on dirty, clean and absent lines tell the three outcomes of R7 apart. A long pseudo-random mix of reads, writes and cleans over four tags in each of eight sets runs against a memory with irregular ready. It is compared with a flat reference memory for data and with a tag/LRU model for the hit flag and for memory traffic on every response. This catches stale write-backs and wrong victims long after the fact.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  localparam int WAYS = 2;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_CLEAN = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WRITEBACK,
    ST_FETCH,
    ST_WRITE_THROUGH,
    ST_RESPOND
  } state_e;
endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store
  import wbc_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int TAG_W = 7
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [$clog2(SETS)-1:0]     rd_idx,
  output logic [WAYS-1:0]             rd_valid,
  output logic [WAYS-1:0]             rd_dirty,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
  input  logic                        wr_en,
  input  logic                        wr_way,
  input  logic [$clog2(SETS)-1:0]     wr_idx,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic                        wr_valid,
  input  logic                        wr_dirty
);
  genvar w;
  generate
    for (w = 0; w < WAYS; w++) begin : g_way
      logic [SETS-1:0]  vld_q;
      logic [SETS-1:0]  drt_q;
      logic [TAG_W-1:0] tag_mem [SETS];
      logic             sel;

      assign sel = wr_en && (wr_way == 1'(w));

      always_ff @(posedge clk) begin
        if (rst) begin
          vld_q <= '0;
          drt_q <= '0;
        end else if (sel) begin
          vld_q[wr_idx] <= wr_valid;
          drt_q[wr_idx] <= wr_dirty;
        end
      end

      always_ff @(posedge clk) begin
        if (sel) tag_mem[wr_idx] <= wr_tag;
      end

      assign rd_valid[w] = vld_q[rd_idx];
      assign rd_dirty[w] = drt_q[rd_idx];
      assign rd_tag[w]   = tag_mem[rd_idx];
    end
  endgenerate
endmodule

// File: rtl/wbc_data_ram.sv
module wbc_data_ram
  import wbc_pkg::*;
#(
  parameter int SETS   = 8,
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rd_en,
  input  logic [$clog2(SETS)-1:0]      rd_idx,
  output logic [WAYS-1:0][DATA_W-1:0]  rd_data,
  input  logic                         wr_en,
  input  logic                         wr_way,
  input  logic [$clog2(SETS)-1:0]      wr_idx,
  input  logic [DATA_W-1:0]            wr_data
);
  genvar w;
  generate
    for (w = 0; w < WAYS; w++) begin : g_way
      logic [DATA_W-1:0] mem [SETS];
      logic [DATA_W-1:0] rd_q;

      always_ff @(posedge clk) begin
        if (wr_en && (wr_way == 1'(w))) mem[wr_idx] <= wr_data;
        if (rd_en) rd_q <= mem[rd_idx];
      end

      assign rd_data[w] = rd_q;
    end
  endgenerate
endmodule

// File: rtl/wbc_lru.sv
module wbc_lru #(
  parameter int SETS = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [$clog2(SETS)-1:0] rd_idx,
  output logic                    rd_lru,
  input  logic                    upd_en,
  input  logic [$clog2(SETS)-1:0] upd_idx,
  input  logic                    upd_used
);
  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lru_q <= '0;
    end else if (upd_en) begin
      lru_q[upd_idx] <= ~upd_used;
    end
  end

  assign rd_lru = lru_q[rd_idx];
endmodule

// File: rtl/wbc_cache_top.sv
module wbc_cache_top
  import wbc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int SETS   = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_hit,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic [CNT_W-1:0]  access_cnt,
  output logic [CNT_W-1:0]  hit_cnt
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  state_e            state_q;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              vic_q;
  logic [TAG_W-1:0]  vic_tag_q;
  logic              fetch_sent_q;
  logic [DATA_W-1:0] rdata_q;
  logic              hit_q;
  logic [CNT_W-1:0]  acc_q;
  logic [CNT_W-1:0]  hitc_q;

  logic [IDX_W-1:0]  idx_q;
  logic [TAG_W-1:0]  tag_q;
  assign idx_q = addr_q[IDX_W-1:0];
  assign tag_q = addr_q[ADDR_W-1:IDX_W];

  logic                       accept;
  logic [WAYS-1:0]            ts_valid;
  logic [WAYS-1:0]            ts_dirty;
  logic [WAYS-1:0][TAG_W-1:0] ts_tag;
  logic                       ts_we;
  logic                       ts_way;
  logic                       ts_wvalid;
  logic                       ts_wdirty;
  logic [WAYS-1:0][DATA_W-1:0] dr_rdata;
  logic                       dr_we;
  logic                       dr_way;
  logic [DATA_W-1:0]          dr_wdata;
  logic                       lru_bit;
  logic                       lru_we;
  logic                       lru_used;
  logic [WAYS-1:0]            hit_vec;
  logic                       hit_any;
  logic                       hit_way;
  logic                       victim;

  assign accept = req_valid && (state_q == ST_IDLE);

  wbc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (idx_q),
    .rd_valid (ts_valid),
    .rd_dirty (ts_dirty),
    .rd_tag   (ts_tag),
    .wr_en    (ts_we),
    .wr_way   (ts_way),
    .wr_idx   (idx_q),
    .wr_tag   (tag_q),
    .wr_valid (ts_wvalid),
    .wr_dirty (ts_wdirty)
  );

  wbc_data_ram #(.SETS(SETS), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rd_en   (accept),
    .rd_idx  (req_addr[IDX_W-1:0]),
    .rd_data (dr_rdata),
    .wr_en   (dr_we),
    .wr_way  (dr_way),
    .wr_idx  (idx_q),
    .wr_data (dr_wdata)
  );

  wbc_lru #(.SETS(SETS)) u_lru (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (idx_q),
    .rd_lru   (lru_bit),
    .upd_en   (lru_we),
    .upd_idx  (idx_q),
    .upd_used (lru_used)
  );

  // Tag compare and victim selection for the latched request
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = ts_valid[w] && (ts_tag[w] == tag_q);
    end
  end
  assign hit_any = |hit_vec;
  assign hit_way = hit_vec[1];
  assign victim  = !ts_valid[0] ? 1'b0 : (!ts_valid[1] ? 1'b1 : lru_bit);

  // Array write controls
  always_comb begin
    ts_we     = 1'b0;
    ts_way    = vic_q;
    ts_wvalid = 1'b1;
    ts_wdirty = 1'b0;
    dr_we     = 1'b0;
    dr_way    = vic_q;
    dr_wdata  = wdata_q;
    lru_we    = 1'b0;
    lru_used  = vic_q;
    case (state_q)
      ST_LOOKUP: begin
        if (hit_any && (op_q == OP_WRITE)) begin
          ts_we     = 1'b1;
          ts_way    = hit_way;
          ts_wdirty = 1'b1;
          dr_we     = 1'b1;
          dr_way    = hit_way;
          lru_we    = 1'b1;
          lru_used  = hit_way;
        end else if (hit_any && (op_q != OP_CLEAN)) begin
          lru_we   = 1'b1;
          lru_used = hit_way;
        end
      end
      ST_WRITEBACK: begin
        if ((op_q == OP_CLEAN) && mem_req_ready) begin
          ts_we = 1'b1;
        end
      end
      ST_FETCH: begin
        if (fetch_sent_q && mem_rsp_valid) begin
          ts_we    = 1'b1;
          dr_we    = 1'b1;
          dr_wdata = mem_rsp_rdata;
          lru_we   = 1'b1;
        end
      end
      default: ;
    endcase
  end

  // Control sequence
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      op_q         <= OP_READ;
      addr_q       <= '0;
      wdata_q      <= '0;
      vic_q        <= 1'b0;
      vic_tag_q    <= '0;
      fetch_sent_q <= 1'b0;
      rdata_q      <= '0;
      hit_q        <= 1'b0;
      acc_q        <= '0;
      hitc_q       <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            op_q    <= (op_e'(req_op) == OP_RSVD) ? OP_READ : op_e'(req_op);
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            state_q <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          hit_q        <= hit_any;
          rdata_q      <= '0;
          fetch_sent_q <= 1'b0;
          if (op_q != OP_CLEAN) begin
            acc_q <= acc_q + CNT_W'(1);
            if (hit_any) hitc_q <= hitc_q + CNT_W'(1);
          end
          case (op_q)
            OP_WRITE: state_q <= hit_any ? ST_RESPOND : ST_WRITE_THROUGH;
            OP_CLEAN: begin
              vic_q     <= hit_way;
              vic_tag_q <= tag_q;
              state_q   <= (hit_any && ts_dirty[hit_way]) ? ST_WRITEBACK : ST_RESPOND;
            end
            default: begin
              if (hit_any) begin
                rdata_q <= dr_rdata[hit_way];
                state_q <= ST_RESPOND;
              end else begin
                vic_q     <= victim;
                vic_tag_q <= ts_tag[victim];
                state_q   <= (ts_valid[victim] && ts_dirty[victim]) ? ST_WRITEBACK : ST_FETCH;
              end
            end
          endcase
        end
        ST_WRITEBACK: begin
          if (mem_req_ready) state_q <= (op_q == OP_CLEAN) ? ST_RESPOND : ST_FETCH;
        end
        ST_FETCH: begin
          if (!fetch_sent_q && mem_req_ready) fetch_sent_q <= 1'b1;
          if (fetch_sent_q && mem_rsp_valid) begin
            rdata_q <= mem_rsp_rdata;
            state_q <= ST_RESPOND;
          end
        end
        ST_WRITE_THROUGH: begin
          if (mem_req_ready) state_q <= ST_RESPOND;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign rsp_valid     = (state_q == ST_RESPOND);
  assign rsp_rdata     = rdata_q;
  assign rsp_hit       = hit_q;
  assign mem_req_valid = (state_q == ST_WRITEBACK) || (state_q == ST_WRITE_THROUGH) ||
                         ((state_q == ST_FETCH) && !fetch_sent_q);
  assign mem_req_we    = (state_q == ST_WRITEBACK) || (state_q == ST_WRITE_THROUGH);
  assign mem_req_addr  = (state_q == ST_WRITEBACK) ? {vic_tag_q, idx_q} : addr_q;
  assign mem_req_wdata = (state_q == ST_WRITEBACK) ? dr_rdata[vic_q] : wdata_q;
  assign access_cnt    = acc_q;
  assign hit_cnt       = hitc_q;
endmodule

// File: rtl/wbc_cache_checker.sv
module wbc_cache_checker #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic [CNT_W-1:0]  access_cnt,
  input logic [CNT_W-1:0]  hit_cnt
);
  // R8: idle and empty right after reset
  a_r8_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_ready && !rsp_valid && !mem_req_valid &&
                    access_cnt == '0 && hit_cnt == '0));

  // R9: acceptance closes the request channel
  a_r9_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R9: completion strobe lasts one cycle
  a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R9: no memory traffic while idle
  a_r9_mem_busy: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  // R11: stalled memory request is held
  a_r11_mem_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_we) && $stable(mem_req_addr) &&
       $stable(mem_req_wdata)));

  // R10: hits never outnumber accesses
  a_r10_hits_bounded: assert property (@(posedge clk) disable iff (rst)
    hit_cnt <= access_cnt);

  // R10: access counter moves by one at most
  a_r10_count_step: assert property (@(posedge clk) disable iff (rst)
    !$stable(access_cnt) |-> (access_cnt == $past(access_cnt) + CNT_W'(1)));
endmodule

bind wbc_cache_top wbc_cache_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .access_cnt    (access_cnt),
  .hit_cnt       (hit_cnt)
);

// File: tb/wbc_cache_top_tb.sv
module wbc_cache_top_tb;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int SETS   = 8;
  localparam int CNT_W  = 16;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [1:0]        req_op = 2'b00;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_rdata;
  logic              rsp_hit;
  logic              mem_req_valid;
  logic              mem_req_ready = 1'b0;
  logic              mem_req_we;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [DATA_W-1:0] mem_req_wdata;
  logic              mem_rsp_valid = 1'b0;
  logic [DATA_W-1:0] mem_rsp_rdata = '0;
  logic [CNT_W-1:0]  access_cnt;
  logic [CNT_W-1:0]  hit_cnt;

  always #2 clk = ~clk;

  wbc_cache_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_hit(rsp_hit), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .access_cnt(access_cnt), .hit_cnt(hit_cnt)
  );

  int checks = 0;
  int fails  = 0;

  function automatic void chk(bit ok, string rq, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endfunction

  // Backing memory model and flat reference copy
  logic [DATA_W-1:0] bmem   [DEPTH];
  logic [DATA_W-1:0] golden [DEPTH];
  int wr_cnt = 0, rd_cnt = 0, wr_stamp = 0, rd_stamp = 0, cyc = 0, pend = 0;
  logic [ADDR_W-1:0] pend_addr = '0;
  logic [15:0] rlfsr = 16'hACE1;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      bmem[i]   = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
      golden[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
    end
  end

  always @(posedge clk) begin
    cyc++;
    mem_rsp_valid <= 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= bmem[pend_addr];
      end
    end
    if (!rst && mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        bmem[mem_req_addr] = mem_req_wdata;
        wr_cnt++;
        wr_stamp = cyc;
      end else begin
        pend_addr = mem_req_addr;
        pend = 2;
        rd_cnt++;
        rd_stamp = cyc;
      end
    end
    rlfsr = {rlfsr[14:0], rlfsr[15] ^ rlfsr[13] ^ rlfsr[12] ^ rlfsr[10]};
    mem_req_ready <= rlfsr[0] | rlfsr[3];
  end

  // Reference tag state
  bit mv [2][SETS];
  bit md [2][SETS];
  int mt [2][SETS];
  int mlru [SETS];
  int m_acc = 0, m_hit = 0;

  typedef struct {
    int op; logic [DATA_W-1:0] rdata; bit hit;
    int nwr; int nrd; int wr0; int rd0; string rq;
  } exp_t;
  exp_t sb[$];

  // Monitor: pop expectation on each response
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R9", "unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(rsp_hit == e.hit, e.rq, "hit flag", rsp_hit, e.hit);
        if (e.op == 0) chk(rsp_rdata == e.rdata, e.rq, "read data", rsp_rdata, e.rdata);
        chk(wr_cnt - e.wr0 == e.nwr, e.rq, "memory writes", wr_cnt - e.wr0, e.nwr);
        chk(rd_cnt - e.rd0 == e.nrd, e.rq, "memory reads", rd_cnt - e.rd0, e.nrd);
        if (e.nwr == 1 && e.nrd == 1)
          chk(wr_stamp < rd_stamp, "R5", "write-back before fetch", wr_stamp, rd_stamp);
      end
    end
  end

  // Driver: predict, push, drive, wait
  task automatic do_req(input int op, input int addr, input logic [DATA_W-1:0] wd, input string hint);
    exp_t e;
    int idx = addr % SETS;
    int tg  = addr / SETS;
    int h   = -1;
    int v;
    for (int w = 0; w < 2; w++) if (mv[w][idx] && mt[w][idx] == tg) h = w;
    e.op = (op == 3) ? 0 : op; e.hit = (h >= 0); e.nwr = 0; e.nrd = 0; e.rdata = '0;
    e.wr0 = wr_cnt; e.rd0 = rd_cnt; e.rq = "";
    case (e.op)
      1: begin
        m_acc++;
        golden[addr] = wd;
        if (h >= 0) begin m_hit++; md[h][idx] = 1; mlru[idx] = 1 - h; e.rq = "R4"; end
        else begin e.nwr = 1; e.rq = "R6"; end
      end
      2: begin
        e.rq = "R7";
        if (h >= 0) begin e.nwr = md[h][idx] ? 1 : 0; md[h][idx] = 0; end
      end
      default: begin
        m_acc++;
        e.rdata = golden[addr];
        if (h >= 0) begin m_hit++; mlru[idx] = 1 - h; e.rq = "R1"; end
        else begin
          v = !mv[0][idx] ? 0 : (!mv[1][idx] ? 1 : mlru[idx]);
          e.nrd = 1;
          e.nwr = (mv[v][idx] && md[v][idx]) ? 1 : 0;
          e.rq  = e.nwr ? "R5" : "R2";
          mv[v][idx] = 1; md[v][idx] = 0; mt[v][idx] = tg; mlru[idx] = 1 - v;
        end
      end
    endcase
    if (hint != "") e.rq = hint;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_addr = ADDR_W'(addr); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9", "ready after accept", req_ready, 0);
    do @(negedge clk); while (sb.size() != 0 || !req_ready);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8", "ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R8", "no response after reset", rsp_valid, 0);
    chk(mem_req_valid == 1'b0, "R8", "no memory request after reset", mem_req_valid, 0);
    chk(access_cnt == 0 && hit_cnt == 0, "R8", "counters after reset", access_cnt, 0);

    // Set 0: tags 2,4,6,8
    do_req(0, 'h010, 0, "R2");           // miss, fills way 0
    do_req(0, 'h010, 0, "R1");           // hit
    do_req(1, 'h010, 32'hD1D1_0001, "R4"); // write hit, dirty
    do_req(0, 'h020, 0, "R3");           // invalid way 1 chosen
    do_req(0, 'h010, 0, "R3");           // hit, LRU -> way 1
    do_req(0, 'h030, 0, "R3");           // evicts 0x020 (clean)
    do_req(0, 'h040, 0, "R5");           // evicts dirty 0x010
    do_req(0, 'h010, 0, "R5");           // returns written-back data
    do_req(1, 'h105, 32'hBEEF_0005, "R6"); // write miss, no allocation
    do_req(0, 'h105, 0, "R6");           // must miss, sees new data
    do_req(1, 'h105, 32'hBEEF_0006, "R4");
    do_req(2, 'h105, 0, "R7");           // dirty clean: one write
    do_req(2, 'h105, 0, "R7");           // now clean: no traffic
    do_req(2, 'h3F7, 0, "R7");           // absent: no traffic
    do_req(3, 'h105, 0, "R7");           // code 11 acts as read hit

    s = 16'h1234;
    for (int n = 0; n < 600; n++) begin
      int a, op;
      s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
      a = ((int'(s[9:8]) + 1) * SETS) + int'(s[2:0]);
      op = (s[7:6] == 2'b11) ? (s[5] ? 2 : 1) : (s[4] ? 1 : 0);
      do_req(op, a, {16'hC0DE, s}, "");
    end

    chk(int'(access_cnt) == m_acc, "R10", "access count", access_cnt, m_acc);
    chk(int'(hit_cnt) == m_hit, "R10", "hit count", hit_cnt, m_hit);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule